// File: doc/BRIEF.md
# Hash/DMA Accelerator Control Register Bank

This block is the software-visible register file of a hash and DMA accelerator. A simple request/acknowledge bus reads and writes 32-bit registers at byte offsets. The registers set the hash algorithm and its options, the FIFO byte-swap modes and the descriptor list base address. They also issue DMA start and restart commands. All of these reach the datapath as plain outputs or single-cycle pulses.

The control registers use a half-word masked write. The upper sixteen bits of a write choose which of the lower sixteen bits change. Software can therefore update one field without first reading the register.

The datapath reports progress through seven one-cycle event inputs. Each event latches into a status register, which software clears by writing ones. The level interrupt is raised while any latched status bit is also enabled. The datapath loads the sixteen digest words one at a time through a load port and marks the digest as ready with a done pulse. Software reads the words back, may clear each one to zero, and acknowledges the ready flag by writing a one.

Bus accesses pass through a two-state access machine. State ACC_IDLE waits for a request. On a request it takes transition T_ACCEPT: a write is applied, or read data is captured, at that edge. In state ACC_RESP the acknowledge is driven for exactly one cycle. Transition T_RETIRE then returns unconditionally to ACC_IDLE.

Top module: `hashdma_csr`

## Requirements
- R1: On the masked registers (DMA command 0x10, FIFO swap 0x40, hash control 0x48), bit n (n = 0..15) of an accepted write changes only when bit n+16 of that write is 1. Every other bit keeps its value.
- R2: A request seen in ACC_IDLE is acknowledged in the following cycle, for one cycle only. A read returns its data together with that acknowledge.
- R3: The interrupt enable register at 0x08 is a plain read/write register of bits 6:0. Bits 31:7 read as 0.
- R4: The interrupt status register at 0x0C latches event input bit k into status bit k. The sources are: bit6 zero-length error, bit5 list error, bit4 source error, bit3 destination error, bit2 source item done, bit1 destination item done, bit0 list done.
- R5: A write to 0x0C clears each status bit written as 1 and leaves each bit written as 0 unchanged.
- R6: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R7: The interrupt output is high exactly while some status bit and its enable bit are both 1.
- R8: At 0x10, a masked write of 1 to bit0 gives one single-cycle start pulse, and a masked write of 1 to bit1 gives one single-cycle restart pulse. The register reads as 0.
- R9: The descriptor list base at 0x14 is a full 32-bit read/write register, driven on an output.
- R10: Hash control at 0x48 has these fields: bits 7:4 algorithm code (0 SHA-1, 1 MD5, 2 SHA-256, 3 SHA-224, 6 SM3, 8 SHA-512, 9 SHA-384, 0xA SHA-512/224, 0xB SHA-512/256), bit3 HMAC enable, bit2 hardware padding, bit1 source select, bit0 hash enable. FIFO control at 0x40 has bit1 output swap and bit0 input swap.
- R11: Digest word i (0..15) reads at 0x3A0 + 4i and is written by the load port. Any bus write to it clears it to 0. A load wins over a clear in the same cycle.
- R12: The ready flag is bit0 at 0x3E4. A done pulse sets it, a write with bit0 = 1 clears it, and a write with bit0 = 0 leaves it alone. Set wins over clear.
- R13: Unmapped offsets read 0, and writes to them change no register.
- R14: After reset every register reads 0, the interrupt is low and no pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request, held until acknowledged |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data (upper half is the mask on masked registers) |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | One-cycle access acknowledge |
| irq_evt | input | 7 | One-cycle event pulses from the datapath |
| res_we | input | 1 | Digest word load strobe |
| res_idx | input | 4 | Digest word index for the load |
| res_data | input | 32 | Digest word value for the load |
| res_done | input | 1 | Digest ready pulse |
| irq | output | 1 | Level interrupt |
| dma_start | output | 1 | One-cycle DMA start pulse |
| dma_restart | output | 1 | One-cycle DMA restart pulse |
| list_base | output | 32 | Descriptor list base address |
| swap_dout | output | 1 | Output byte-swap enable |
| swap_din | output | 1 | Input byte-swap enable |
| hash_algo | output | 4 | Hash algorithm code |
| hash_hmac | output | 1 | HMAC enable |
| hash_pad | output | 1 | Hardware padding enable |
| hash_src_sel | output | 1 | Hash source select |
| hash_en | output | 1 | Hash enable |

## Verification
The bench writes control registers with partial and empty masks. A design that ignored the mask would overwrite fields that software never meant to touch. It also fires an event in the same cycle as a clearing write to that status bit, and a done pulse together with a flag clear. If clear won over set, an event would be lost silently. The bench checks that a status bit stays latched while its enable is off. A design that gated status by the enable would never raise a deferred interrupt. Finally, it touches offsets at the edge of the digest window and next to mapped registers, and checks for one start pulse per command, so an off-by-one decode or a stretched pulse is caught.

// File: rtl/hashdma_csr_pkg.sv
package hashdma_csr_pkg;

    localparam logic [11:0] OFF_IRQ_EN    = 12'h008;
    localparam logic [11:0] OFF_IRQ_ST    = 12'h00C;
    localparam logic [11:0] OFF_DMA_CMD   = 12'h010;
    localparam logic [11:0] OFF_LIST_BASE = 12'h014;
    localparam logic [11:0] OFF_FIFO_SWAP = 12'h040;
    localparam logic [11:0] OFF_HASH_CFG  = 12'h048;
    localparam logic [11:0] OFF_RES_BASE  = 12'h3A0;
    localparam logic [11:0] OFF_RES_FLAG  = 12'h3E4;

    localparam int CMD_START_BIT   = 0;
    localparam int CMD_RESTART_BIT = 1;

    typedef enum logic [0:0] {
        ACC_IDLE = 1'b0,
        ACC_RESP = 1'b1
    } acc_state_t;

    typedef struct packed {
        logic [3:0] algo;
        logic       hmac;
        logic       pad;
        logic       src_sel;
        logic       enable;
    } hash_cfg_t;

endpackage

// File: rtl/hdc_access_fsm.sv
module hdc_access_fsm
    import hashdma_csr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic wr,
    output logic accept_wr,
    output logic accept_rd,
    output logic ack
);

    acc_state_t state_q;
    acc_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // T_ACCEPT: ACC_IDLE -> ACC_RESP on req; T_RETIRE: ACC_RESP -> ACC_IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: if (req) state_d = ACC_RESP;
            ACC_RESP: state_d = ACC_IDLE;
            default:  state_d = ACC_IDLE;
        endcase
    end

    always_comb begin
        accept_wr = 1'b0;
        accept_rd = 1'b0;
        ack       = 1'b0;
        unique case (state_q)
            ACC_IDLE: begin
                accept_wr = req && wr;
                accept_rd = req && !wr;
            end
            ACC_RESP: ack = 1'b1;
            default:  ack = 1'b0;
        endcase
    end

endmodule

// File: rtl/hdc_mask_reg.sv
module hdc_mask_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wval,
    input  logic [W-1:0] wmask,
    output logic [W-1:0] q
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[b] <= 1'b0;
            end else if (wr_en && wmask[b]) begin
                q[b] <= wval[b];
            end
        end
    end

endmodule

// File: rtl/hdc_irq_unit.sv
module hdc_irq_unit #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_we,
    input  logic         st_we,
    input  logic [N-1:0] wval,
    input  logic [N-1:0] evt,
    output logic [N-1:0] enable,
    output logic [N-1:0] status,
    output logic         irq
);

    logic [N-1:0] clr_bits;

    assign clr_bits = st_we ? wval : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable <= '0;
        end else if (en_we) begin
            enable <= wval;
        end
    end

    // an event in the same cycle as a clear leaves the bit set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
        end else begin
            status <= (status & ~clr_bits) | evt;
        end
    end

    assign irq = |(status & enable);

endmodule

// File: rtl/hdc_result_bank.sv
module hdc_result_bank #(
    parameter int WORDS = 16,
    parameter int W     = 32,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_we,
    input  logic [IW-1:0] load_idx,
    input  logic [W-1:0]  load_data,
    input  logic          load_done,
    input  logic          clr_we,
    input  logic [IW-1:0] clr_idx,
    input  logic          flag_clr,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_word,
    output logic          ready
);

    logic [W-1:0] words [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                words[i] <= '0;
            end else if (load_we && (load_idx == IW'(i))) begin
                words[i] <= load_data;
            end else if (clr_we && (clr_idx == IW'(i))) begin
                words[i] <= '0;
            end
        end
    end

    assign rd_word = words[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready <= 1'b0;
        end else if (load_done) begin
            ready <= 1'b1;
        end else if (flag_clr) begin
            ready <= 1'b0;
        end
    end

endmodule

// File: rtl/hashdma_csr.sv
module hashdma_csr
    import hashdma_csr_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int IRQ_SRCS  = 7,
    parameter int RES_WORDS = 16,
    parameter int FIFO_W    = 2,
    parameter int HASH_W    = 8,
    parameter int CMD_W     = 2,
    localparam int HALF     = DATA_W / 2,
    localparam int RES_IW   = $clog2(RES_WORDS),
    localparam int RES_SPAN = RES_WORDS * 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ack,
    input  logic [IRQ_SRCS-1:0] irq_evt,
    input  logic              res_we,
    input  logic [RES_IW-1:0] res_idx,
    input  logic [DATA_W-1:0] res_data,
    input  logic              res_done,
    output logic              irq,
    output logic              dma_start,
    output logic              dma_restart,
    output logic [DATA_W-1:0] list_base,
    output logic              swap_dout,
    output logic              swap_din,
    output logic [3:0]        hash_algo,
    output logic              hash_hmac,
    output logic              hash_pad,
    output logic              hash_src_sel,
    output logic              hash_en
);

    logic accept_wr;
    logic accept_rd;

    hdc_access_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (bus_req),
        .wr        (bus_wr),
        .accept_wr (accept_wr),
        .accept_rd (accept_rd),
        .ack       (bus_ack)
    );

    // address decode
    logic hit_irq_en, hit_irq_st, hit_cmd, hit_list, hit_fifo, hit_hash, hit_flag;
    logic hit_res;
    logic [ADDR_W-1:0] res_off;
    logic [RES_IW-1:0] bus_res_idx;

    assign hit_irq_en = (bus_addr == ADDR_W'(OFF_IRQ_EN));
    assign hit_irq_st = (bus_addr == ADDR_W'(OFF_IRQ_ST));
    assign hit_cmd    = (bus_addr == ADDR_W'(OFF_DMA_CMD));
    assign hit_list   = (bus_addr == ADDR_W'(OFF_LIST_BASE));
    assign hit_fifo   = (bus_addr == ADDR_W'(OFF_FIFO_SWAP));
    assign hit_hash   = (bus_addr == ADDR_W'(OFF_HASH_CFG));
    assign hit_flag   = (bus_addr == ADDR_W'(OFF_RES_FLAG));

    assign res_off     = bus_addr - ADDR_W'(OFF_RES_BASE);
    assign hit_res     = (bus_addr >= ADDR_W'(OFF_RES_BASE)) &&
                         (res_off < ADDR_W'(RES_SPAN)) &&
                         (bus_addr[1:0] == 2'b00);
    assign bus_res_idx = res_off[RES_IW+1:2];

    // masked control registers
    logic [FIFO_W-1:0] fifo_q;
    logic [HASH_W-1:0] hash_q;
    hash_cfg_t         hash_cfg;

    hdc_mask_reg #(.W(FIFO_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (accept_wr && hit_fifo),
        .wval  (bus_wdata[FIFO_W-1:0]),
        .wmask (bus_wdata[HALF +: FIFO_W]),
        .q     (fifo_q)
    );

    hdc_mask_reg #(.W(HASH_W)) u_hash (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (accept_wr && hit_hash),
        .wval  (bus_wdata[HASH_W-1:0]),
        .wmask (bus_wdata[HALF +: HASH_W]),
        .q     (hash_q)
    );

    assign hash_cfg     = hash_cfg_t'(hash_q);
    assign hash_algo    = hash_cfg.algo;
    assign hash_hmac    = hash_cfg.hmac;
    assign hash_pad     = hash_cfg.pad;
    assign hash_src_sel = hash_cfg.src_sel;
    assign hash_en      = hash_cfg.enable;
    assign swap_dout    = fifo_q[1];
    assign swap_din     = fifo_q[0];

    // command pulses: masked, self-clearing, never stored
    logic [CMD_W-1:0] cmd_fire;
    logic [CMD_W-1:0] cmd_q;

    for (genvar c = 0; c < CMD_W; c++) begin : g_cmd
        assign cmd_fire[c] = accept_wr && hit_cmd && bus_wdata[HALF + c] && bus_wdata[c];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cmd_q[c] <= 1'b0;
            end else begin
                cmd_q[c] <= cmd_fire[c];
            end
        end
    end

    assign dma_start   = cmd_q[CMD_START_BIT];
    assign dma_restart = cmd_q[CMD_RESTART_BIT];

    // list base
    logic [DATA_W-1:0] list_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            list_q <= '0;
        end else if (accept_wr && hit_list) begin
            list_q <= bus_wdata;
        end
    end

    assign list_base = list_q;

    // interrupts
    logic [IRQ_SRCS-1:0] irq_enable;
    logic [IRQ_SRCS-1:0] irq_status;

    hdc_irq_unit #(.N(IRQ_SRCS)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_we  (accept_wr && hit_irq_en),
        .st_we  (accept_wr && hit_irq_st),
        .wval   (bus_wdata[IRQ_SRCS-1:0]),
        .evt    (irq_evt),
        .enable (irq_enable),
        .status (irq_status),
        .irq    (irq)
    );

    // digest words and ready flag
    logic [DATA_W-1:0] res_word;
    logic              res_valid_q;

    hdc_result_bank #(.WORDS(RES_WORDS), .W(DATA_W)) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_we   (res_we),
        .load_idx  (res_idx),
        .load_data (res_data),
        .load_done (res_done),
        .clr_we    (accept_wr && hit_res),
        .clr_idx   (bus_res_idx),
        .flag_clr  (accept_wr && hit_flag && bus_wdata[0]),
        .rd_idx    (bus_res_idx),
        .rd_word   (res_word),
        .ready     (res_valid_q)
    );

    // read mux and capture
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        rd_mux = '0;
        if (hit_irq_en)      rd_mux = DATA_W'(irq_enable);
        else if (hit_irq_st) rd_mux = DATA_W'(irq_status);
        else if (hit_list)   rd_mux = list_q;
        else if (hit_fifo)   rd_mux = DATA_W'(fifo_q);
        else if (hit_hash)   rd_mux = DATA_W'(hash_q);
        else if (hit_flag)   rd_mux = DATA_W'(res_valid_q);
        else if (hit_res)    rd_mux = res_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (accept_rd) begin
            rdata_q <= rd_mux;
        end
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/hashdma_csr_chk.sv
module hashdma_csr_chk
    import hashdma_csr_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int IRQ_SRCS = 7,
    parameter int HASH_W   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_req,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic                bus_ack,
    input logic [IRQ_SRCS-1:0] irq_evt,
    input logic [IRQ_SRCS-1:0] irq_status,
    input logic                irq,
    input logic                dma_start,
    input logic                res_done,
    input logic                res_valid_q,
    input logic [HASH_W-1:0]   hash_q
);

    assert_ack_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    assert_ack_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> $past(bus_req));

    assert_event_latched_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_evt) |=> ((irq_status & $past(irq_evt)) == $past(irq_evt)));

    assert_irq_rise_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past((|irq_evt) || (bus_req && bus_wr && !bus_ack)));

    assert_start_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |=> !dma_start);

    assert_start_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |-> $past(bus_req && bus_wr && !bus_ack &&
                            bus_addr == ADDR_W'(OFF_DMA_CMD) &&
                            bus_wdata[DATA_W/2] && bus_wdata[0]));

    assert_unmasked_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_wr && !bus_ack && bus_addr == ADDR_W'(OFF_HASH_CFG) &&
         bus_wdata[DATA_W/2 +: HASH_W] == '0) |=> $stable(hash_q));

    assert_ready_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
        res_done |=> res_valid_q);

endmodule

bind hashdma_csr hashdma_csr_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .IRQ_SRCS (IRQ_SRCS),
    .HASH_W   (HASH_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_req     (bus_req),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_ack     (bus_ack),
    .irq_evt     (irq_evt),
    .irq_status  (irq_status),
    .irq         (irq),
    .dma_start   (dma_start),
    .res_done    (res_done),
    .res_valid_q (res_valid_q),
    .hash_q      (hash_q)
);

// File: tb/hashdma_csr_tb_top.sv
module hashdma_csr_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ack;
    logic [6:0]  irq_evt = '0;
    logic        res_we = 1'b0;
    logic [3:0]  res_idx = '0;
    logic [31:0] res_data = '0;
    logic        res_done = 1'b0;
    logic        irq, dma_start, dma_restart;
    logic [31:0] list_base;
    logic        swap_dout, swap_din;
    logic [3:0]  hash_algo;
    logic        hash_hmac, hash_pad, hash_src_sel, hash_en;

    int n_cmp = 0;
    int n_bad = 0;
    int n_start = 0;
    int n_restart = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hashdma_csr dut_i (
        .clk (clk), .rst_n (rst_n),
        .bus_req (bus_req), .bus_wr (bus_wr), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .bus_ack (bus_ack),
        .irq_evt (irq_evt), .res_we (res_we), .res_idx (res_idx),
        .res_data (res_data), .res_done (res_done), .irq (irq),
        .dma_start (dma_start), .dma_restart (dma_restart),
        .list_base (list_base), .swap_dout (swap_dout), .swap_din (swap_din),
        .hash_algo (hash_algo), .hash_hmac (hash_hmac), .hash_pad (hash_pad),
        .hash_src_sel (hash_src_sel), .hash_en (hash_en)
    );

    always @(negedge clk) begin
        if (dma_start)   n_start++;
        if (dma_restart) n_restart++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input bit wr, input logic [11:0] a, input logic [31:0] d,
                        output logic [31:0] q);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        chk("R2 ack after accept", {31'b0, bus_ack}, 32'd1);
        q = bus_rdata;
        bus_req = 1'b0; bus_wr = 1'b0;
        @(negedge clk);
        chk("R2 ack one cycle", {31'b0, bus_ack}, 32'd0);
    endtask

    task automatic wr32(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] unused_q;
        xfer(1'b1, a, d, unused_q);
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] q;
        xfer(1'b0, a, 32'h0, q);
        chk(tag, q, exp);
    endtask

    task automatic pulse_evt(input logic [6:0] v);
        @(negedge clk); irq_evt = v;
        @(negedge clk); irq_evt = '0;
    endtask

    task automatic t_reset();
        chk("R14 irq low", {31'b0, irq}, 32'd0);
        rd_chk("R14 irq enable", 12'h008, 32'h0);
        rd_chk("R14 irq status", 12'h00C, 32'h0);
        rd_chk("R14 list base", 12'h014, 32'h0);
        rd_chk("R14 fifo", 12'h040, 32'h0);
        rd_chk("R14 hash cfg", 12'h048, 32'h0);
        rd_chk("R14 digest word0", 12'h3A0, 32'h0);
        rd_chk("R14 ready flag", 12'h3E4, 32'h0);
        chk("R14 no start pulse", n_start, 0);
    endtask

    task automatic t_masked();
        wr32(12'h048, 32'h00FF_0024);
        rd_chk("R1 full mask write", 12'h048, 32'h24);
        chk("R10 algo SHA-256", {28'b0, hash_algo}, 32'd2);
        chk("R10 pad bit2", {31'b0, hash_pad}, 32'd1);
        wr32(12'h048, 32'h0001_0001);
        rd_chk("R1 single bit mask", 12'h048, 32'h25);
        chk("R10 enable bit0", {31'b0, hash_en}, 32'd1);
        wr32(12'h048, 32'h0000_00FF);
        rd_chk("R1 empty mask ignored", 12'h048, 32'h25);
        wr32(12'h048, 32'h00F0_0090);
        rd_chk("R1 algo field only", 12'h048, 32'h95);
        chk("R10 algo SHA-384", {28'b0, hash_algo}, 32'd9);
        chk("R10 hmac off", {31'b0, hash_hmac}, 32'd0);
        wr32(12'h048, 32'h000A_000A);
        chk("R10 hmac bit3", {31'b0, hash_hmac}, 32'd1);
        chk("R10 src sel bit1", {31'b0, hash_src_sel}, 32'd1);
        rd_chk("R1 hash after bits 3,1", 12'h048, 32'h9F);
        wr32(12'h040, 32'h0003_0003);
        chk("R10 swap out", {31'b0, swap_dout}, 32'd1);
        chk("R10 swap in", {31'b0, swap_din}, 32'd1);
        wr32(12'h040, 32'h0002_0000);
        rd_chk("R1 fifo partial clear", 12'h040, 32'h1);
        chk("R10 swap out cleared", {31'b0, swap_dout}, 32'd0);
    endtask

    task automatic t_dma_cmd();
        wr32(12'h010, 32'h0001_0001);
        @(negedge clk);
        chk("R8 one start pulse", n_start, 1);
        chk("R8 no restart", n_restart, 0);
        rd_chk("R8 cmd reads zero", 12'h010, 32'h0);
        wr32(12'h010, 32'h0000_0001);
        @(negedge clk);
        chk("R8 unmasked start ignored", n_start, 1);
        wr32(12'h010, 32'h0002_0002);
        @(negedge clk);
        chk("R8 one restart pulse", n_restart, 1);
        chk("R8 start unchanged", n_start, 1);
    endtask

    task automatic t_list();
        wr32(12'h014, 32'hDEAD_BEE0);
        rd_chk("R9 list base readback", 12'h014, 32'hDEAD_BEE0);
        chk("R9 list base output", list_base, 32'hDEAD_BEE0);
    endtask

    task automatic t_irq();
        wr32(12'h008, 32'hFFFF_FFFF);
        rd_chk("R3 enable width", 12'h008, 32'h7F);
        wr32(12'h008, 32'h0);
        pulse_evt(7'h41);
        rd_chk("R4 list done and zero-len latched", 12'h00C, 32'h41);
        chk("R7 masked irq low", {31'b0, irq}, 32'd0);
        wr32(12'h008, 32'h01);
        chk("R7 irq after enable", {31'b0, irq}, 32'd1);
        wr32(12'h00C, 32'h01);
        rd_chk("R5 w1c bit0", 12'h00C, 32'h40);
        chk("R7 irq low after clear", {31'b0, irq}, 32'd0);
        wr32(12'h00C, 32'h0);
        rd_chk("R5 zero write keeps", 12'h00C, 32'h40);
        wr32(12'h008, 32'h40);
        chk("R7 irq on zero-len", {31'b0, irq}, 32'd1);
        wr32(12'h00C, 32'h40);
        chk("R7 irq low after w1c", {31'b0, irq}, 32'd0);
        pulse_evt(7'h08);
        rd_chk("R4 destination error bit3", 12'h00C, 32'h08);
        wr32(12'h00C, 32'h08);
        wr32(12'h008, 32'h0);
    endtask

    task automatic t_set_wins();
        pulse_evt(7'h02);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b1; bus_addr = 12'h00C; bus_wdata = 32'h2;
        irq_evt = 7'h02;
        @(negedge clk);
        irq_evt = '0; bus_req = 1'b0; bus_wr = 1'b0;
        @(negedge clk);
        rd_chk("R6 event beats clear", 12'h00C, 32'h02);
        wr32(12'h00C, 32'h02);
        rd_chk("R5 cleared afterwards", 12'h00C, 32'h0);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b1; bus_addr = 12'h3E4; bus_wdata = 32'h1;
        res_done = 1'b1;
        @(negedge clk);
        res_done = 1'b0; bus_req = 1'b0; bus_wr = 1'b0;
        @(negedge clk);
        rd_chk("R12 done beats clear", 12'h3E4, 32'h1);
        wr32(12'h3E4, 32'h1);
    endtask

    task automatic t_result();
        @(negedge clk); res_we = 1'b1; res_idx = 4'd0;  res_data = 32'h1111_1111;
        @(negedge clk); res_idx = 4'd15; res_data = 32'hFFFF_0000;
        @(negedge clk); res_idx = 4'd7;  res_data = 32'h1234_5678;
        @(negedge clk); res_we = 1'b0;
        rd_chk("R11 word0", 12'h3A0, 32'h1111_1111);
        rd_chk("R11 word15", 12'h3DC, 32'hFFFF_0000);
        rd_chk("R11 word7", 12'h3BC, 32'h1234_5678);
        wr32(12'h3BC, 32'h0000_AAAA);
        rd_chk("R11 bus write clears", 12'h3BC, 32'h0);
        rd_chk("R11 neighbour kept", 12'h3DC, 32'hFFFF_0000);
    endtask

    task automatic t_ready();
        @(negedge clk); res_done = 1'b1;
        @(negedge clk); res_done = 1'b0;
        rd_chk("R12 set by done", 12'h3E4, 32'h1);
        wr32(12'h3E4, 32'h0);
        rd_chk("R12 zero write ignored", 12'h3E4, 32'h1);
        wr32(12'h3E4, 32'h1);
        rd_chk("R12 cleared", 12'h3E4, 32'h0);
    endtask

    task automatic t_unmapped();
        wr32(12'h044, 32'hFFFF_FFFF);
        rd_chk("R13 unmapped reads zero", 12'h044, 32'h0);
        wr32(12'h04C, 32'hFFFF_FFFF);
        rd_chk("R13 hash cfg untouched", 12'h048, 32'h9F);
        rd_chk("R13 gap after digest", 12'h3E0, 32'h0);
        rd_chk("R13 unaligned digest", 12'h3A2, 32'h0);
        rd_chk("R13 fifo untouched", 12'h040, 32'h1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masked();
        t_dma_cmd();
        t_list();
        t_irq();
        t_set_wins();
        t_result();
        t_ready();
        t_unmapped();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R2 watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule